// File: doc/BRIEF.md
# Wait-for-interrupt clock gating controller

This block sits in the always-clocked part of one core and handles the core's idle sequence. When the pipeline asks to wait for an interrupt, the controller holds the core clock on. It waits until the core has retired all its instructions, until every outstanding load, maintenance operation and exclusive store has received its response from level 2, and until no store is still waiting to reach the cache or level 2. Only then does it drop the core clock enable. Throughout, the core stays powered, so only clock power is saved.

While the core is gated, the controller keeps watching three kinds of side request: a level-2 snoop into the L1 data cache, a cache, TLB or branch-predictor maintenance request, and a debug-bus access to core-domain debug or trace registers. It records each one, turns the clock back on one cycle before it grants the core permission to act, and returns the acknowledge to the requester. It gates the clock again when nothing is left pending. The low-power flag stays high through this service window. A wake event or reset takes the core back to normal running.

Top module: `wfi_clkgate_ctrl`

## Requirements
- R1: Reset, asynchronous and active low, forces the running state. Clock enable is 1, the low-power flag is 0, and all pending side requests are cleared, so grant and acknowledge outputs are 0.
- R2: Only an asserted wait-for-interrupt request starts the entry sequence. With no request, the clock enable stays 1 even when the core is fully idle.
- R3: Once a request has been taken, the clock is gated only when the in-flight instruction count and the outstanding load count are both zero and the maintenance-pending and exclusive-pending flags are both clear. Request seen at edge 1 and idle inputs at edge 2 give clock enable 0 and low-power flag 1 after edge 2.
- R4: An ordinary store blocks gating only while its unissued flag is high. No completion of stores already issued is waited for.
- R5: A wake event while draining cancels entry. The block returns to running without the clock enable ever dropping.
- R6: A wake event while the low-power flag is high gives clock enable 1 and low-power flag 0 after the next edge.
- R7: A side-request strobe (bit 0 snoop, bit 1 maintenance, bit 2 debug) seen while gated raises the clock enable two edges later, with the low-power flag still 1. The one-hot grant to the core appears no earlier than one cycle after the clock enable has been high.
- R8: When several side requests are pending, they are granted one at a time in the order snoop, maintenance, debug. Grant and acknowledge are one-hot on the same bit positions.
- R9: While a grant is asserted and the core reports completion, the matching acknowledge bit is high in that cycle. Once nothing is pending, the clock is gated again within two edges while the low-power flag stays 1.
- R10: A wake event during side service takes priority and returns to running. A request still pending is then granted with the clock running.
- R11: Side-request strobes that arrive while running or draining are not recorded and never produce a grant or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wfi_req_i | input | 1 | Wait-for-interrupt request from the pipeline |
| inflight_cnt_i | input | CNT_W | Instructions not yet retired |
| load_cnt_i | input | CNT_W | Loads awaiting level-2 data |
| maint_pend_i | input | 1 | Cache or TLB maintenance awaiting response |
| excl_pend_i | input | 1 | Exclusive store awaiting response |
| store_unissued_i | input | 1 | A store has neither updated the cache nor been issued to level 2 |
| side_req_i | input | 3 | Side-request strobes: bit 0 snoop, bit 1 maintenance, bit 2 debug |
| side_done_i | input | 1 | Core has finished the granted side request |
| wake_i | input | 1 | Wake-up event |
| core_clk_en_o | output | 1 | Enable for the core clock gate |
| lowpwr_o | output | 1 | Core is in the low-power state |
| side_grant_o | output | 3 | One-hot permission for the core to serve a side request |
| side_ack_o | output | 3 | One-hot acknowledge back to the requester |

## Verification
The assertions check four things on every cycle. The clock is only ever gated while the low-power flag is high. The low-power flag rises only after a cycle in which all drain conditions held and no wake was present. A grant never comes without the clock enable having been high for a full cycle before it. A wake event while in low power always restores the clock at the next edge. Some behaviour only the bench scenarios can show: the service order when several side requests are pending at once, the return to gating after the last acknowledge, the abort of entry by a wake while draining, the survival of a pending request across a wake, and the dropping of side strobes while running.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_SERVICE = 2'd3
  } wfi_state_e;

  localparam int unsigned SIDE_N = 3;  // bit 0 snoop, 1 maintenance, 2 debug
endpackage

// File: rtl/wfi_drain_check.sv
module wfi_drain_check #(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] inflight_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             maint_i,
  input  logic             excl_i,
  input  logic             store_unissued_i,
  output logic             quiet_o
);
  logic cnt_zero;
  logic flag_zero;

  assign cnt_zero  = (inflight_i == '0) && (load_i == '0);
  // issued stores do not hold off gating
  assign flag_zero = !(maint_i || excl_i || store_unissued_i);
  assign quiet_o   = cnt_zero && flag_zero;
endmodule

// File: rtl/wfi_side_arb.sv
module wfi_side_arb
  import wfi_pkg::*;
#(
  parameter int unsigned N = SIDE_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         capture_i,
  input  logic         serve_ok_i,
  input  logic         done_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] ack_o,
  output logic         any_pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;
  logic [N-1:0] blocked;

  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign blocked[i] = 1'b0;
    end else begin : g_rest
      assign blocked[i] = blocked[i-1] | pend_q[i-1];
    end
    assign grant_o[i] = serve_ok_i & pend_q[i] & ~blocked[i];
    assign ack_o[i]   = grant_o[i] & done_i;
    assign pend_d[i]  = (pend_q[i] & ~ack_o[i]) | (capture_i & req_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign any_pend_o = |pend_q;
endmodule

// File: rtl/wfi_seq_fsm.sv
module wfi_seq_fsm
  import wfi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wfi_req_i,
  input  logic       wake_i,
  input  logic       quiet_i,
  input  logic       any_pend_i,
  output wfi_state_e state_o,
  output logic       clk_en_o,
  output logic       warm_o,
  output logic       capture_o
);
  wfi_state_e state_q, state_d;
  logic       clk_en_q;
  logic       warm_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (wfi_req_i) state_d = ST_DRAIN;
      ST_DRAIN:   if (wake_i) state_d = ST_RUN;
                  else if (quiet_i) state_d = ST_SLEEP;
      ST_SLEEP:   if (wake_i) state_d = ST_RUN;
                  else if (any_pend_i) state_d = ST_SERVICE;
      ST_SERVICE: if (wake_i) state_d = ST_RUN;
                  else if (!any_pend_i) state_d = ST_SLEEP;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      clk_en_q <= 1'b1;
      warm_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      clk_en_q <= (state_d != ST_SLEEP);
      warm_q   <= clk_en_q;  // one full enabled cycle before any grant
    end
  end

  assign state_o   = state_q;
  assign clk_en_o  = clk_en_q;
  assign warm_o    = warm_q;
  assign capture_o = (state_d == ST_SLEEP) || (state_d == ST_SERVICE);
endmodule

// File: rtl/wfi_clkgate_ctrl.sv
module wfi_clkgate_ctrl
  import wfi_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wfi_req_i,
  input  logic [CNT_W-1:0]  inflight_cnt_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              maint_pend_i,
  input  logic              excl_pend_i,
  input  logic              store_unissued_i,
  input  logic [SIDE_N-1:0] side_req_i,
  input  logic              side_done_i,
  input  logic              wake_i,
  output logic              core_clk_en_o,
  output logic              lowpwr_o,
  output logic [SIDE_N-1:0] side_grant_o,
  output logic [SIDE_N-1:0] side_ack_o
);
  logic       quiet;
  logic       any_pend;
  logic       capture;
  logic       warm;
  logic       clk_en;
  wfi_state_e state;

  wfi_drain_check #(.CNT_W(CNT_W)) u_drain (
    .inflight_i       (inflight_cnt_i),
    .load_i           (load_cnt_i),
    .maint_i          (maint_pend_i),
    .excl_i           (excl_pend_i),
    .store_unissued_i (store_unissued_i),
    .quiet_o          (quiet)
  );

  wfi_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wfi_req_i  (wfi_req_i),
    .wake_i     (wake_i),
    .quiet_i    (quiet),
    .any_pend_i (any_pend),
    .state_o    (state),
    .clk_en_o   (clk_en),
    .warm_o     (warm),
    .capture_o  (capture)
  );

  wfi_side_arb #(.N(SIDE_N)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (side_req_i),
    .capture_i  (capture),
    .serve_ok_i (clk_en & warm),
    .done_i     (side_done_i),
    .grant_o    (side_grant_o),
    .ack_o      (side_ack_o),
    .any_pend_o (any_pend)
  );

  assign core_clk_en_o = clk_en;
  assign lowpwr_o      = (state == ST_SLEEP) || (state == ST_SERVICE);
endmodule

// File: rtl/wfi_clkgate_ctrl_chk.sv
module wfi_clkgate_ctrl_chk
  import wfi_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wfi_req_i,
  input logic [CNT_W-1:0]  inflight_cnt_i,
  input logic [CNT_W-1:0]  load_cnt_i,
  input logic              maint_pend_i,
  input logic              excl_pend_i,
  input logic              store_unissued_i,
  input logic [SIDE_N-1:0] side_req_i,
  input logic              side_done_i,
  input logic              wake_i,
  input logic              core_clk_en_o,
  input logic              lowpwr_o,
  input logic [SIDE_N-1:0] side_grant_o,
  input logic [SIDE_N-1:0] side_ack_o
);
  logic idle_in;
  assign idle_in = (inflight_cnt_i == '0) && (load_cnt_i == '0) &&
                   !maint_pend_i && !excl_pend_i && !store_unissued_i;

  AST_GATED_ONLY_LOWPWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_clk_en_o |-> lowpwr_o);  // R3

  AST_ENTRY_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lowpwr_o) |-> $past(idle_in));  // R3

  AST_ENTRY_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lowpwr_o) |-> !$past(wake_i));  // R5

  AST_WAKE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lowpwr_o && wake_i) |=> (!lowpwr_o && core_clk_en_o));  // R6

  AST_GRANT_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|side_grant_o) |-> (core_clk_en_o && $past(core_clk_en_o)));  // R7

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(side_grant_o) && $onehot0(side_ack_o));  // R8

  AST_ACK_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|side_ack_o) |-> (side_done_i && ((side_ack_o & ~side_grant_o) == '0)));  // R9
endmodule

bind wfi_clkgate_ctrl wfi_clkgate_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/wfi_clkgate_ctrl_test.sv
`timescale 1ns/1ps
module wfi_clkgate_ctrl_test;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic [3:0] inflight;
    logic [3:0] loads;
    logic       maint;
    logic       excl;
    logic       stu;
    logic       exp_sleep;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  4'd0,  1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd3,  4'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd0,  4'd1,  1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd0,  4'd0,  1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd0,  4'd0,  1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd0,  4'd0,  1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd15, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic wfi_req;
  logic [CNT_W-1:0] inflight, loads;
  logic maint, excl, stu, side_done, wake;
  logic [2:0] side_req, grant, ack;
  logic clk_en, lowpwr;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wfi_clkgate_ctrl #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wfi_req_i(wfi_req),
    .inflight_cnt_i(inflight), .load_cnt_i(loads),
    .maint_pend_i(maint), .excl_pend_i(excl), .store_unissued_i(stu),
    .side_req_i(side_req), .side_done_i(side_done), .wake_i(wake),
    .core_clk_en_o(clk_en), .lowpwr_o(lowpwr),
    .side_grant_o(grant), .side_ack_o(ack)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string rq, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wfi_req = 0; inflight = '0; loads = '0; maint = 0; excl = 0; stu = 0;
    side_req = '0; side_done = 0; wake = 0;
  endtask

  task automatic enter_sleep();
    idle_inputs();
    wfi_req = 1; step(); wfi_req = 0; step();
  endtask

  task automatic leave_sleep();
    wake = 1; step(); wake = 0; step();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_ni = 0;
    #12;
    chk("R1 clk_en", clk_en, 1); chk("R1 lowpwr", lowpwr, 0);
    chk("R1 grant", grant, 0);   chk("R1 ack", ack, 0);
    @(negedge clk); rst_ni = 1;
    step();

    // R2: fully idle but no request
    repeat (5) step();
    chk("R2 clk_en", clk_en, 1); chk("R2 lowpwr", lowpwr, 0);

    // R3 / R4 drain table
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = VECS[i].stu ? "R4" : "R3";
      idle_inputs();
      inflight = VECS[i].inflight; loads = VECS[i].loads;
      maint = VECS[i].maint; excl = VECS[i].excl; stu = VECS[i].stu;
      wfi_req = 1; step(); wfi_req = 0;
      chk(rq, clk_en, 1);
      step();
      chk(rq, lowpwr, VECS[i].exp_sleep);
      chk(rq, clk_en, !VECS[i].exp_sleep);
      wake = 1; step(); wake = 0;
      idle_inputs();
      chk(VECS[i].exp_sleep ? "R6" : "R5", {lowpwr, clk_en}, 2'b01);
      step();
    end

    // R5: wake aborts drain even when drain completes in the same cycle
    idle_inputs(); inflight = 4'd1;
    wfi_req = 1; step(); wfi_req = 0;
    chk("R5 draining", clk_en, 1);
    inflight = '0; wake = 1; step(); wake = 0;
    chk("R5 no gate", {lowpwr, clk_en}, 2'b01);
    repeat (3) step();
    chk("R5 stays run", {lowpwr, clk_en}, 2'b01);

    // R7 / R9 single debug access
    enter_sleep();
    chk("R7 asleep", {lowpwr, clk_en}, 2'b10);
    side_req = 3'b100; step(); side_req = '0;
    chk("R7 still gated", clk_en, 0);
    step();
    chk("R7 clk on", {lowpwr, clk_en}, 2'b11);
    chk("R7 no grant yet", grant, 0);
    step();
    chk("R7 grant", grant, 3'b100);
    side_done = 1; #1;
    chk("R9 ack", ack, 3'b100);
    step(); side_done = 0;
    chk("R9 ack drop", ack, 0);
    step();
    chk("R9 regate", {lowpwr, clk_en}, 2'b10);

    // R8 priority with all three pending
    side_req = 3'b111; step(); side_req = '0;
    step(); step();
    chk("R8 first snoop", grant, 3'b001);
    side_done = 1; #1;
    chk("R8 ack snoop", ack, 3'b001);
    step();
    chk("R8 then maint", grant, 3'b010);
    step();
    chk("R8 then debug", grant, 3'b100);
    chk("R8 ack debug", ack, 3'b100);
    step(); side_done = 0;
    chk("R9 still lowpwr", {lowpwr, clk_en}, 2'b11);
    step();
    chk("R9 regate all", {lowpwr, clk_en}, 2'b10);
    leave_sleep();

    // R10 wake during service
    enter_sleep();
    side_req = 3'b010; step(); side_req = '0;
    step();
    chk("R10 service", {lowpwr, clk_en}, 2'b11);
    wake = 1; step(); wake = 0;
    chk("R10 run", {lowpwr, clk_en}, 2'b01);
    chk("R10 pending grant", grant, 3'b010);
    side_done = 1; #1;
    chk("R10 ack", ack, 3'b010);
    step(); side_done = 0;
    chk("R10 cleared", grant, 0);

    // R11 strobes in run are dropped
    side_req = 3'b111; step(); side_req = '0;
    repeat (3) step();
    chk("R11 run grant", grant, 0); chk("R11 run ack", ack, 0);

    // R11 strobe in drain is dropped
    idle_inputs(); inflight = 4'd2;
    wfi_req = 1; step(); wfi_req = 0;
    side_req = 3'b001; step(); side_req = '0;
    inflight = '0; step();
    repeat (4) step();
    chk("R11 drain stays gated", {lowpwr, clk_en}, 2'b10);
    chk("R11 drain grant", grant, 0);

    // R1 reset while asleep with a request pending
    side_req = 3'b100; step(); side_req = '0;
    rst_ni = 0; #1;
    chk("R1 async clk_en", clk_en, 1); chk("R1 async lowpwr", lowpwr, 0);
    @(negedge clk); rst_ni = 1;
    repeat (4) step();
    chk("R1 pending cleared", grant, 0);
    chk("R1 run after reset", {lowpwr, clk_en}, 2'b01);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule